// File: doc/BRIEF.md
# Interrupt Source PQ State Buffer

This block keeps a two-bit coalescing state, P and Q, for each source in a small array of interrupt sources. P set means the source has been sent to the event queue and is waiting for end-of-interrupt (EOI). Q set means the source fired again while P was set. A hardware trigger on a source with both bits clear produces exactly one notification, carrying the source number, toward a downstream queue. Later triggers only record themselves in Q, so a source never sits in the queue more than once.

Software reaches the state through a load/store port, one 4 KB page per source. Special load offsets return the state from before the access and can also overwrite it or perform an EOI, all in one atomic step. A store at a fixed offset performs EOI on sources built to accept it. On EOI, a set Q bit re-arms the source and sends a fresh notification. Otherwise the state is cleared.

Top module: `pq_state_buf`

## Requirements
- R1: After reset every source holds PQ=01 (masked). No notification is valid and no load response is valid.
- R2: A load returns one cycle after its request, with `mmio_rvalid` high for one cycle. The data is the source's PQ value from before the access, with P in bit 1 and Q in bit 0. Bits 63:2 are zero.
- R3: A load at page offset 0x800 returns the state and leaves it unchanged.
- R4: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 set PQ to 00, 01, 10 and 11 respectively, taken from address bits 9:8.
- R5: A trigger on PQ=00 moves it to 10 and emits one notification carrying the source index. A trigger on 10 moves it to 11. A trigger on 11 leaves it at 11. Neither of the last two emits anything.
- R6: A trigger on PQ=01 is ignored. The state stays 01 and nothing is emitted.
- R7: A load at offset 0x000 performs EOI. If Q=1 the state becomes 10 and a new notification is emitted. If the state is 00 or 10 it becomes 00. The state 01 is left unchanged.
- R8: A store at offset 0x400 performs EOI on sources whose bit in `STORE_EOI_EN` is set. On other sources it is ignored, and stores never produce a load response.
- R9: Notifications use a valid/ready handshake. A notification is held while `ntf_ready` is low and is never dropped. When several are waiting, the lowest source index goes first.
- R10: When a trigger and an access hit the same source in one cycle, the access is applied first and the trigger is applied to its result.
- R11: The source is selected by address bits 12 and up. A load at any other offset within the page returns the state without changing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | NSRC | Per-source hardware trigger pulses |
| mmio_req | input | 1 | Access request |
| mmio_we | input | 1 | 1 = store, 0 = load |
| mmio_addr | input | 12+log2(NSRC) | Byte address; bits 11:0 are the page offset, the upper bits select the source |
| mmio_rvalid | output | 1 | Load response valid |
| mmio_rdata | output | 64 | Load response, previous PQ in bits 1:0 |
| ntf_valid | output | 1 | Notification valid |
| ntf_ready | input | 1 | Downstream accepts the notification |
| ntf_src | output | log2(NSRC) | Source index of the notification |

## Verification
A load's response is registered and appears one cycle after the edge that samples the request. A notification becomes visible one cycle after the edge that samples the trigger or EOI causing it, and stays valid until an edge where `ntf_ready` is high. The bench drives inputs 1 ns after a rising edge and samples outputs at the falling edge. Response and notification monitors compare against expected values queued by the driver. State changes and ignored stimuli are confirmed with a later non-modifying read at offset 0x800, together with idle checks on `ntf_valid`.

// File: rtl/pq_state_buf.sv
module pq_state_buf #(
  parameter int NSRC = 8,
  parameter logic [NSRC-1:0] STORE_EOI_EN = '1,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int AW = 12 + SW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] trig,
  input  logic            mmio_req,
  input  logic            mmio_we,
  input  logic [AW-1:0]   mmio_addr,
  output logic            mmio_rvalid,
  output logic [63:0]     mmio_rdata,
  output logic            ntf_valid,
  input  logic            ntf_ready,
  output logic [SW-1:0]   ntf_src
);

  logic [1:0]      pq_q  [NSRC];
  logic [1:0]      pq_nx [NSRC];
  logic [NSRC-1:0] need_q, need_nx;
  logic [1:0]      old_pq, rd_q;
  logic            rvalid_q;

  wire [SW-1:0] sel     = mmio_addr[AW-1:12];
  wire          magic   = (mmio_addr[7:0] == 8'h00);
  wire          is_load = mmio_req & ~mmio_we;
  wire          ld_eoi  = is_load & magic & (mmio_addr[11:8] == 4'h0);
  wire          ld_set  = is_load & magic & (mmio_addr[11:10] == 2'b11);
  wire          st_eoi  = mmio_req & mmio_we & magic & (mmio_addr[11:8] == 4'h4);

  always_comb begin
    ntf_src = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (need_q[i]) ntf_src = i[SW-1:0];
  end
  assign ntf_valid = |need_q;

  always_comb begin
    old_pq = 2'b00;
    for (int i = 0; i < NSRC; i++) begin
      logic       hit, emit;
      logic [1:0] m;
      hit  = mmio_req && (sel == i[SW-1:0]);
      m    = pq_q[i];
      emit = 1'b0;
      if (hit) old_pq = pq_q[i];
      if (hit && (ld_eoi || (st_eoi && STORE_EOI_EN[i]))) begin
        if (m != 2'b01) begin
          if (m[0]) begin
            m    = 2'b10;
            emit = 1'b1;
          end else begin
            m = 2'b00;
          end
        end
      end else if (hit && ld_set) begin
        m = mmio_addr[9:8];
      end
      if (trig[i]) begin
        case (m)
          2'b00:   begin m = 2'b10; emit = 1'b1; end
          2'b10:   m = 2'b11;
          default: m = m;
        endcase
      end
      pq_nx[i] = m;
      need_nx[i] = (need_q[i] & ~(ntf_valid & ntf_ready & (ntf_src == i[SW-1:0]))) | emit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) pq_q[i] <= 2'b01;
      need_q   <= '0;
      rvalid_q <= 1'b0;
      rd_q     <= 2'b00;
    end else begin
      for (int i = 0; i < NSRC; i++) pq_q[i] <= pq_nx[i];
      need_q   <= need_nx;
      rvalid_q <= is_load;
      if (is_load) rd_q <= old_pq;
    end
  end

  assign mmio_rvalid = rvalid_q;
  assign mmio_rdata  = {62'd0, rd_q};

endmodule

// File: rtl/pq_state_buf_chk.sv
module pq_state_buf_chk #(
  parameter int NSRC = 8,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mmio_req,
  input logic          mmio_we,
  input logic          mmio_rvalid,
  input logic [63:0]   mmio_rdata,
  input logic          ntf_valid,
  input logic          ntf_ready,
  input logic [SW-1:0] ntf_src
);

  p_load_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_req && !mmio_we |=> mmio_rvalid);

  p_resp_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_rvalid |-> (mmio_rdata[63:2] == 62'd0));

  p_store_no_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_req && mmio_we |=> !mmio_rvalid);

  p_ntf_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid && !ntf_ready |=> ntf_valid);

  p_ntf_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> (int'(ntf_src) < NSRC));

endmodule

bind pq_state_buf pq_state_buf_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mmio_req(mmio_req), .mmio_we(mmio_we),
  .mmio_rvalid(mmio_rvalid), .mmio_rdata(mmio_rdata),
  .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_src(ntf_src)
);

// File: tb/sim_pq_state_buf.sv
`timescale 1ns/1ps
module sim_pq_state_buf;
  localparam int NSRC = 8;
  localparam int SW = 3;
  localparam int AW = 12 + SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] trig = '0;
  logic mmio_req = 1'b0, mmio_we = 1'b0;
  logic [AW-1:0] mmio_addr = '0;
  logic mmio_rvalid;
  logic [63:0] mmio_rdata;
  logic ntf_valid;
  logic ntf_ready = 1'b1;
  logic [SW-1:0] ntf_src;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [1:0] rq[$];
  string rt[$];
  int nq[$];

  always #2.5 clk = ~clk;

  pq_state_buf #(.NSRC(NSRC), .STORE_EOI_EN(8'h7F)) u0 (
    .clk(clk), .rst_n(rst_n), .trig(trig), .mmio_req(mmio_req), .mmio_we(mmio_we),
    .mmio_addr(mmio_addr), .mmio_rvalid(mmio_rvalid), .mmio_rdata(mmio_rdata),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_src(ntf_src));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ld(input int s, input logic [11:0] off, input logic [1:0] exp,
                    input string tag, input logic [NSRC-1:0] trg = '0);
    @(posedge clk); #1;
    mmio_req = 1'b1; mmio_we = 1'b0; mmio_addr = {s[SW-1:0], off}; trig = trg;
    rq.push_back(exp); rt.push_back(tag);
    @(posedge clk); #1;
    mmio_req = 1'b0; trig = '0;
  endtask

  task automatic st(input int s, input logic [11:0] off);
    @(posedge clk); #1;
    mmio_req = 1'b1; mmio_we = 1'b1; mmio_addr = {s[SW-1:0], off};
    @(posedge clk); #1;
    mmio_req = 1'b0; mmio_we = 1'b0;
  endtask

  task automatic pulse(input int s);
    @(posedge clk); #1;
    trig = '0; trig[s] = 1'b1;
    @(posedge clk); #1;
    trig = '0;
  endtask

  task automatic idle(input string tag);
    repeat (3) @(negedge clk);
    check(!ntf_valid, tag, ntf_valid, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && mmio_rvalid) begin
      if (rq.size() == 0) check(1'b0, "R2 unexpected response", mmio_rdata, 0);
      else begin
        logic [1:0] e;
        string t;
        e = rq.pop_front(); t = rt.pop_front();
        check(mmio_rdata == {62'd0, e}, t, mmio_rdata, e);
      end
    end
    if (rst_n && ntf_valid && ntf_ready) begin
      if (nq.size() == 0) check(1'b0, "R5 unexpected notification", ntf_src, -1);
      else begin
        int e;
        e = nq.pop_front();
        check(int'(ntf_src) == e, "R5/R9 notification source", ntf_src, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!ntf_valid, "R1 no notification after reset", ntf_valid, 0);
    check(!mmio_rvalid, "R1 no response after reset", mmio_rvalid, 0);
    ld(0, 12'h800, 2'b01, "R1 source 0 masked");
    ld(7, 12'h800, 2'b01, "R1 source 7 masked");

    pulse(0);
    idle("R6 masked trigger silent");
    ld(0, 12'h800, 2'b01, "R6 masked state kept");

    ld(0, 12'hC00, 2'b01, "R4 set 00 returns old");
    ld(0, 12'h800, 2'b00, "R3 get after set 00");
    ld(0, 12'h800, 2'b00, "R3 get leaves state");

    nq.push_back(0);
    pulse(0);
    pulse(0);
    pulse(0);
    idle("R5 only one notification");
    ld(0, 12'h800, 2'b11, "R5 retriggers coalesce to 11");

    nq.push_back(0);
    ld(0, 12'h000, 2'b11, "R7 eoi returns 11");
    idle("R7 single retrigger");
    ld(0, 12'h800, 2'b10, "R7 eoi with Q gives 10");
    ld(0, 12'h000, 2'b10, "R7 eoi returns 10");
    ld(0, 12'h800, 2'b00, "R7 eoi without Q clears");

    ld(1, 12'hD00, 2'b01, "R4 set 01");
    ld(1, 12'h000, 2'b01, "R7 eoi on masked");
    ld(1, 12'h800, 2'b01, "R7 masked unchanged by eoi");

    ld(2, 12'hF00, 2'b01, "R4 set 11");
    nq.push_back(2);
    st(2, 12'h400);
    idle("R8 store eoi single notification");
    ld(2, 12'h800, 2'b10, "R8 store eoi gives 10");
    ld(7, 12'hF00, 2'b01, "R4 set 11 on source 7");
    st(7, 12'h400);
    idle("R8 unsupported store eoi silent");
    ld(7, 12'h800, 2'b11, "R8 unsupported store ignored");

    ld(3, 12'hE00, 2'b01, "R4 set 10");
    ld(3, 12'h800, 2'b10, "R4 state 10 after set");
    ld(3, 12'h100, 2'b10, "R11 plain offset returns old");
    ld(3, 12'h800, 2'b10, "R11 plain offset no change");

    @(posedge clk); #1 ntf_ready = 1'b0;
    ld(5, 12'hC00, 2'b01, "R4 set 00 source 5");
    ld(4, 12'hC00, 2'b01, "R4 set 00 source 4");
    nq.push_back(4); nq.push_back(5);
    pulse(5);
    pulse(4);
    repeat (2) @(negedge clk);
    check(ntf_valid && ntf_src == 3'd4, "R9 lowest index first", ntf_src, 4);
    repeat (4) @(negedge clk);
    check(ntf_valid && ntf_src == 3'd4, "R9 held while stalled", ntf_src, 4);
    @(posedge clk); #1 ntf_ready = 1'b1;
    idle("R9 both delivered");

    ld(6, 12'hF00, 2'b01, "R4 set 11 source 6");
    nq.push_back(6);
    ld(6, 12'h000, 2'b11, "R10 eoi with trigger", 8'h40);
    idle("R10 one notification");
    ld(6, 12'h800, 2'b11, "R10 trigger after eoi gives 11");
    nq.push_back(6);
    ld(6, 12'hC00, 2'b11, "R10 set 00 with trigger", 8'h40);
    idle("R10 trigger on fresh 00");
    ld(6, 12'h800, 2'b10, "R10 set then trigger gives 10");

    repeat (5) @(posedge clk);
    check(rq.size() == 0, "R2 all responses seen", rq.size(), 0);
    check(nq.size() == 0, "R9 all notifications seen", nq.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule